// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Interface

This block sits between a three-wire serial host link and a two-channel 8-bit converter. The host lowers an active-low select line and clocks a 16-bit command word in most significant bit first. Each bit is taken on a falling edge of the serial clock. All three serial lines are sampled by a faster system clock through two-flop synchronisers. Edges are detected in the system-clock domain.

The word carries a two-bit register-select code, a speed bit, a power-down bit and twelve data bits. The select code can load channel B together with a shared holding buffer, or load only the buffer. It can also write channel A while the buffer is moved into channel B in the same cycle, so that both outputs change together. The last code writes the reference-source field. The speed and power-down bits are taken from every accepted word. The latched codes and the mode and reference settings drive the analog section directly.

A frame normally ends after its sixteenth bit. If the select line rises earlier, the bits received so far are transferred, right-aligned. Extra clocks after a complete frame have no effect until the select line goes high and then low again.

Top module: `dsdac_cmd_if`

## Requirements
- R1: A frame starts when sel_n_i falls. Within a frame, sdi_i is sampled on each falling edge of sclk_i, most significant bit first. Falling sclk_i edges while sel_n_i is high change nothing.
- R2: After 16 bits the word is applied once. Further sclk_i edges in the same frame change no output until sel_n_i goes high and then low again.
- R3: If sel_n_i rises after n bits, with 1 <= n <= 15, the n received bits are applied as a word with those bits in its n lowest positions and zeros above them. If sel_n_i rises with no bits received, nothing is applied.
- R4: The word layout is: bit 15 = select high bit, bit 14 = speed, bit 13 = power-down, bit 12 = select low bit. For channel and buffer writes the 8-bit code is bits 11:4; bits 3:0 are not used.
- R5: Select code 2'b10 (bit15, bit12) loads the code into channel B and into the holding buffer. Channel A is unchanged.
- R6: Select code 2'b11 loads only the holding buffer. Both channel outputs are unchanged.
- R7: Select code 2'b00 loads the code into channel A and copies the holding buffer into channel B, with both outputs changing on the same system clock edge.
- R8: Select code 2'b01 sets ref_sel_o to data bits 1:0 (00 external, 01 internal low, 10 internal high, 11 external). Bits 11:2 are ignored, and both channel outputs are unchanged.
- R9: fast_o takes bit 14 (1 = fast) and pdown_o takes bit 13 (1 = power-down) of every applied word, whatever its select code.
- R10: After reset, both channel codes, the holding buffer, fast_o, pdown_o and ref_sel_o are zero.
- R11: The affected outputs change on the fourth rising clk edge after the sclk_i falling edge that delivers the 16th bit, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Active-low frame select from the host |
| sclk_i | input | 1 | Serial bit clock; data is taken on its falling edge |
| sdi_i | input | 1 | Serial data in, MSB first |
| code_a_o | output | 8 | Latched channel A converter code |
| code_b_o | output | 8 | Latched channel B converter code |
| fast_o | output | 1 | Speed mode, 1 = fast |
| pdown_o | output | 1 | Power-down, 1 = powered down |
| ref_sel_o | output | 2 | Reference source select |

## Verification
The assertions assume that every level of sclk_i and sel_n_i lasts at least two system clocks. They also assume that sdi_i is stable for two clocks before and after each falling serial clock edge, and that a select edge never falls in the same synchroniser window as a serial clock fall. The stimulus meets these conditions by bit-banging at an eight-cycle serial period. Data changes two cycles before sclk_i rises, and four idle cycles separate each select edge from the nearest clock edge. Random words, random short frames and random trailing clocks all stay within this timing.

// File: rtl/dsdac_pkg.sv
package dsdac_pkg;
  localparam int WORD_W = 16;
  localparam int CODE_W = 8;
  localparam int REF_W  = 2;
  localparam int BIT_SELH = 15;
  localparam int BIT_FAST = 14;
  localparam int BIT_PDN  = 13;
  localparam int BIT_SELL = 12;
  localparam int CODE_LSB = 4;

  typedef enum logic [1:0] {
    SEL_A_XFER = 2'b00,
    SEL_CTRL   = 2'b01,
    SEL_B_BUF  = 2'b10,
    SEL_BUF    = 2'b11
  } sel_e;

  function automatic sel_e word_sel(input logic [WORD_W-1:0] w);
    return sel_e'({w[BIT_SELH], w[BIT_SELL]});
  endfunction

  function automatic logic [CODE_W-1:0] word_code(input logic [WORD_W-1:0] w);
    return w[CODE_LSB +: CODE_W];
  endfunction

  function automatic logic [REF_W-1:0] word_ref(input logic [WORD_W-1:0] w);
    return w[REF_W-1:0];
  endfunction
endpackage

// File: rtl/dsdac_sync.sv
module dsdac_sync #(
  parameter int             WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/dsdac_shifter.sv
module dsdac_shifter
  import dsdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic              load_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic              sel_n_q, sclk_q;
  logic              sel_fall, sel_rise, sclk_fall, in_frame;
  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;

  assign sel_fall  = sel_n_q & ~sel_n_s;
  assign sel_rise  = ~sel_n_q & sel_n_s;
  assign sclk_fall = sclk_q & ~sclk_s;
  assign in_frame  = ~sel_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_n_q <= 1'b1;
      sclk_q  <= 1'b0;
      shreg_q <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b1;
      load_o  <= 1'b0;
      word_o  <= '0;
    end else begin
      sel_n_q <= sel_n_s;
      sclk_q  <= sclk_s;
      load_o  <= 1'b0;
      if (sel_fall) begin
        shreg_q <= '0;
        cnt_q   <= '0;
        done_q  <= 1'b0;
      end else if (in_frame && sclk_fall && !done_q) begin
        shreg_q <= {shreg_q[WORD_W-2:0], sdi_s};
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == LAST_IDX) begin
          done_q <= 1'b1;
          load_o <= 1'b1;
          word_o <= {shreg_q[WORD_W-2:0], sdi_s};
        end
      end else if (sel_rise && !done_q) begin
        done_q <= 1'b1;
        if (cnt_q != '0) begin
          load_o <= 1'b1;
          word_o <= shreg_q;
        end
      end
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORD_W));

  assert_single_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);

  assert_idle_clock_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n_s && sel_n_q && sclk_fall) |=> ($stable(cnt_q) && !load_o));

  assert_done_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !sel_fall) |=> (!load_o && $stable(cnt_q)));
endmodule

// File: rtl/dsdac_regs.sv
module dsdac_regs
  import dsdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic              fast_o,
  output logic              pdown_o,
  output logic [REF_W-1:0]  ref_sel_o
);
  logic [CODE_W-1:0] hold_q;
  logic [CODE_W-1:0] new_code;
  sel_e              sel;
  logic              unused_low_bits;

  assign new_code        = word_code(word_i);
  assign sel             = word_sel(word_i);
  assign unused_low_bits = ^word_i[CODE_LSB-1:REF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      code_a_o  <= '0;
      code_b_o  <= '0;
      fast_o    <= 1'b0;
      pdown_o   <= 1'b0;
      ref_sel_o <= '0;
    end else if (load_i) begin
      fast_o  <= word_i[BIT_FAST];
      pdown_o <= word_i[BIT_PDN];
      unique case (sel)
        SEL_B_BUF: begin
          code_b_o <= new_code;
          hold_q   <= new_code;
        end
        SEL_BUF:    hold_q    <= new_code;
        SEL_A_XFER: begin
          code_a_o <= new_code;
          code_b_o <= hold_q;
        end
        SEL_CTRL:   ref_sel_o <= word_ref(word_i);
        default: ;
      endcase
    end
  end

  assert_joint_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && sel == SEL_A_XFER) |=>
      (code_a_o == $past(new_code) && code_b_o == $past(hold_q)));

  assert_buf_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && sel == SEL_BUF) |=> ($stable(code_a_o) && $stable(code_b_o)));

  assert_ctrl_keeps_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && sel == SEL_CTRL) |=>
      ($stable(code_a_o) && $stable(code_b_o) && ref_sel_o == $past(word_i[1:0])));

  assert_b_and_buf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && sel == SEL_B_BUF) |=> ($stable(code_a_o) && code_b_o == hold_q));

  assert_mode_every_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (fast_o == $past(word_i[BIT_FAST]) && pdown_o == $past(word_i[BIT_PDN])));

  assert_quiet_without_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(code_a_o) && $stable(code_b_o) && $stable(ref_sel_o)));
endmodule

// File: rtl/dsdac_cmd_if.sv
module dsdac_cmd_if
  import dsdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic              fast_o,
  output logic              pdown_o,
  output logic [REF_W-1:0]  ref_sel_o
);
  logic [2:0]        pins_s;
  logic              load_p;
  logic [WORD_W-1:0] word;

  dsdac_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({sel_n_i, sclk_i, sdi_i}),
    .q_o   (pins_s)
  );

  dsdac_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_n_s (pins_s[2]),
    .sclk_s  (pins_s[1]),
    .sdi_s   (pins_s[0]),
    .load_o  (load_p),
    .word_o  (word)
  );

  dsdac_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_p),
    .word_i    (word),
    .code_a_o  (code_a_o),
    .code_b_o  (code_b_o),
    .fast_o    (fast_o),
    .pdown_o   (pdown_o),
    .ref_sel_o (ref_sel_o)
  );

  assert_reset_clear_R10: assert property (@(posedge clk)
    $rose(rst_n) |-> (code_a_o == '0 && code_b_o == '0 && !fast_o && !pdown_o && ref_sel_o == '0));
endmodule

// File: tb/dsdac_cmd_if_bench.sv
module dsdac_cmd_if_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [7:0] code_a, code_b;
  logic fast, pdown;
  logic [1:0] ref_sel;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_a = 0, m_b = 0, m_buf = 0;
  logic m_fast = 0, m_pd = 0;
  logic [1:0] m_ref = 0;

  always #4 clk = ~clk;

  dsdac_cmd_if u_dsdac_cmd_if (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sclk_i(sclk), .sdi_i(sdi),
    .code_a_o(code_a), .code_b_o(code_b), .fast_o(fast), .pdown_o(pdown),
    .ref_sel_o(ref_sel)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " code_a"}, 32'(code_a), 32'(m_a));
    chk({req, " code_b"}, 32'(code_b), 32'(m_b));
    chk({req, " fast"}, 32'(fast), 32'(m_fast));
    chk({req, " pdown"}, 32'(pdown), 32'(m_pd));
    chk({req, " ref"}, 32'(ref_sel), 32'(m_ref));
  endtask

  // Bench model of the command decode, written from the requirements.
  task automatic model(input logic [15:0] w, input int nbits);
    logic [15:0] v;
    logic [7:0] c;
    if (nbits == 0) return;
    v = (nbits >= 16) ? w : (w >> (16 - nbits));
    c = v[11:4];
    m_fast = v[14];
    m_pd   = v[13];
    case ({v[15], v[12]})
      2'b10: begin m_b = c; m_buf = c; end
      2'b11: m_buf = c;
      2'b00: begin m_b = m_buf; m_a = c; end
      default: m_ref = v[1:0];
    endcase
  endtask

  function automatic logic [15:0] mk(input logic [1:0] s, input logic f, input logic p,
                                     input logic [11:0] d);
    return {s[1], f, p, s[0], d};
  endfunction

  task automatic bit_out(input logic b);
    sdi = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input int extra);
    @(negedge clk); sel_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits + extra; i++)
      bit_out(i < 16 ? w[15 - i] : 1'($urandom));
    repeat (4) @(negedge clk);
    sel_n = 1'b1;
    repeat (8) @(negedge clk);
    model(w, nbits);
  endtask

  // 16-bit frame with edge-by-edge checks after the last serial fall (R11, R7).
  task automatic send_timed(input logic [15:0] w, input string req);
    logic [7:0] old_a, old_b;
    old_a = m_a; old_b = m_b;
    @(negedge clk); sel_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 15; i++) bit_out(w[15 - i]);
    sdi = w[0];
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    model(w, 16);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({req, " R11 a before 4th edge"}, 32'(code_a), 32'(old_a));
    chk({req, " R11 b before 4th edge"}, 32'(code_b), 32'(old_b));
    @(negedge clk);
    chk({req, " R11 a at 4th edge"}, 32'(code_a), 32'(m_a));
    chk({req, " R11 b at 4th edge"}, 32'(code_b), 32'(m_b));
    repeat (4) @(negedge clk);
    sel_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h0D5A_C126));
    repeat (5) @(negedge clk);
    chk_all("R10 in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_all("R10 after reset");

    // R10: buffer cleared: transfer into B without loading the buffer first.
    send(mk(2'b00, 1'b0, 1'b0, 12'h5A0), 16, 0);
    chk_all("R10 buffer zero, R7");

    // R5 then R6 then R7 directed sequence.
    send(mk(2'b10, 1'b1, 1'b0, 12'h3C0), 16, 0);
    chk_all("R5 b and buffer, R9 fast");
    send(mk(2'b11, 1'b0, 1'b1, 12'hE70), 16, 0);
    chk_all("R6 buffer only, R9 pdown");
    send_timed(mk(2'b00, 1'b1, 1'b0, 12'h910), "R7 joint");
    chk_all("R7 joint update");

    // R8: control write, upper data ignored, every reference code.
    for (int r = 0; r < 4; r++) begin
      send(mk(2'b01, 1'b0, 1'b1, {10'h3FF, 2'(r)}), 16, 0);
      chk_all("R8 ref select");
    end

    // R4: low data bits 3:0 set do not leak into the code.
    send(mk(2'b10, 1'b0, 1'b0, 12'hA5F), 16, 0);
    chk_all("R4 code from bits 11:4");

    // R1: clocks while select is high change nothing.
    sdi = 1'b1;
    for (int i = 0; i < 20; i++) begin
      repeat (2) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk); sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    chk_all("R1 idle clocks ignored");
    send(mk(2'b00, 1'b0, 1'b0, 12'h6B0), 16, 0);
    chk_all("R1 frame after idle clocks");

    // R2: trailing clocks after 16 bits ignored.
    send(mk(2'b10, 1'b1, 1'b1, 12'h7E0), 16, 5);
    chk_all("R2 extra clocks ignored");

    // R3: short frames, including an empty one.
    send(16'hFFFF, 0, 0);
    chk_all("R3 empty frame");
    send(16'hFFF0, 12, 0);
    chk_all("R3 short frame right-aligned");
    send(16'h9A50, 15, 0);
    chk_all("R3 fifteen bits");

    // R11 timing on a B write.
    send_timed(mk(2'b10, 1'b0, 1'b0, 12'hC30), "R11 b write");

    // Random mix of all select codes, short frames and trailing clocks.
    for (int k = 0; k < 50; k++) begin
      logic [15:0] w;
      int nb, ex;
      w  = 16'($urandom);
      nb = ($urandom % 6 == 0) ? int'($urandom % 16) : 16;
      ex = (nb == 16 && $urandom % 4 == 0) ? int'($urandom % 4) : 0;
      send(w, nb, ex);
      chk_all("R9 R5 R6 R7 R8 random");
    end

    finish_run();
  end
endmodule